// File: doc/BRIEF.md
# SIMT Divergence Mask Stack

This block tracks which lanes of an 8-lane warp are enabled while the warp runs through predicated if/else code. Each lane either executes the instruction issued to the warp or stays idle for that cycle. The enable vector is `active_mask`. A compare operation turns each lane's operand into a predicate bit, and the active mask is left alone.

A branch operation then checks the predicate against the active lanes. If every active lane agrees, the warp moves as a whole. All-false is reported as a taken branch. All-true falls through. If the active lanes disagree, the current mask and the else-side lanes are saved on a small stack, and the warp goes on down the fall-through side with only the lanes whose predicate is true. A later switch operation installs the saved else-side lanes. A restore operation then pops the stack and brings back the mask that was in force before the split.

The operation code is a plain control input that is sampled on every clock. There is no streaming data path, so there is no back-pressure. Every status output is registered and changes on the clock edge after the operation is sampled.

Top module: `simt_div_ctrl`

## Requirements
- R1: After reset, `active_mask` is all ones, `pred_mask` is zero, `stk_depth` is 0, `stk_empty` is 1, and `br_taken`, `ovf_err` and `udf_err` are 0.
- R2: Operation code 1 (compare) sets `pred_mask[i]` to 1 exactly when lane i's operand `lane_vals_i[i*8 +: 8]` is non-zero. The active mask and the stack are left unchanged.
- R3: Operation code 2 (branch) is divergent when both `active_mask & pred_mask` and `active_mask & ~pred_mask` are non-zero. With the stack not full, a divergent branch pushes one entry, and on the next cycle `active_mask` equals the old mask ANDed with the predicate and `br_taken` is 0.
- R4: On a branch where `active_mask & pred_mask` is zero, `br_taken` is 1 for one cycle. On a branch where every active lane has its predicate set, `br_taken` stays 0. In both cases the mask and the stack depth do not change. Predicate bits of inactive lanes have no effect.
- R5: Operation code 3 (switch to else) with a non-empty stack sets `active_mask` to the old mask ANDed with the inverted predicate, as recorded by the most recent push. The stack depth is unchanged.
- R6: Operation code 4 (restore) with a non-empty stack sets `active_mask` to the mask saved by the most recent push and lowers `stk_depth` by one.
- R7: A switch or restore on an empty stack leaves the mask unchanged and raises `udf_err` for exactly one cycle.
- R8: A divergent branch while `stk_depth` equals DEPTH (default 4, signalled by `stk_full`) pushes nothing, leaves the mask unchanged, and raises `ovf_err` for one cycle.
- R9: Nested splits unwind in last-in first-out order. Each restore returns the mask of the enclosing level.
- R10: Operation code 0 and the unused codes 5 to 7 change no state, and all pulse outputs read 0 after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code: 0 none, 1 compare, 2 branch, 3 switch, 4 restore |
| lane_vals_i | input | 64 | Per-lane compare operands, 8 bits per lane, lane 0 in the low byte |
| active_mask | output | 8 | Current lane enable vector |
| pred_mask | output | 8 | Predicate from the last compare |
| br_taken | output | 1 | One-cycle pulse: the warp branches as a whole |
| stk_depth | output | 3 | Number of saved entries |
| stk_empty | output | 1 | Stack holds no entries |
| stk_full | output | 1 | Stack holds DEPTH entries |
| ovf_err | output | 1 | One-cycle pulse: divergent branch refused on a full stack |
| udf_err | output | 1 | One-cycle pulse: switch or restore on an empty stack |

## Verification
The assertions check several properties on every cycle. A compare never changes the mask, and a branch never enables a lane that was idle. A uniform branch leaves the depth unchanged, and the depth never exceeds its bound. A restore lowers the depth by exactly one, and an operation on an empty stack always produces the underflow pulse with the mask held. Only the bench scenarios can show that the correct saved values come back. This covers the else-lanes installed by the switch, the last-in first-out order of nested restores, the rejection at a full stack, and the ignoring of predicate bits that belong to idle lanes.

// File: rtl/simt_pkg.sv
package simt_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_CMP    = 3'd1,
    OP_BRANCH = 3'd2,
    OP_SWITCH = 3'd3,
    OP_RESTORE = 3'd4
  } simt_op_e;

  localparam int unsigned LANE_CNT = 8;

  typedef struct packed {
    logic [LANE_CNT-1:0] saved;
    logic [LANE_CNT-1:0] alt;
  } frame_t;
endpackage

// File: rtl/simt_pred_unit.sv
module simt_pred_unit #(
  parameter int unsigned LANES = 8,
  parameter int unsigned VW    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [LANES*VW-1:0]   vals,
  output logic [LANES-1:0]      pred
);
  logic [LANES-1:0] nz;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign nz[g] = |vals[g*VW +: VW];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pred <= '0;
    else if (load_en) pred <= nz;
  end
endmodule

// File: rtl/simt_frame_stack.sv
module simt_frame_stack
  import simt_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  frame_t        push_frame,
  output frame_t        top_frame,
  output logic [DW-1:0] depth,
  output logic          empty,
  output logic          full
);
  frame_t          slots [DEPTH];
  logic [DW-1:0]   dm1;

  assign dm1       = depth - DW'(1);
  assign empty     = (depth == '0);
  assign full      = (depth == DW'(DEPTH));
  assign top_frame = slots[dm1[AW-1:0]];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        slots[s] <= '0;
      else if (push && !full && depth[AW-1:0] == AW'(s))
        slots[s] <= push_frame;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               depth <= '0;
    else if (push && !full)   depth <= depth + DW'(1);
    else if (pop && !empty)   depth <= dm1;
  end

  // R6
  pop_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> (depth == $past(depth) - DW'(1)));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));
endmodule

// File: rtl/simt_div_ctrl.sv
module simt_div_ctrl
  import simt_pkg::*;
#(
  parameter int unsigned VW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned LANES = LANE_CNT,
  localparam int unsigned DW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          op_i,
  input  logic [LANES*VW-1:0] lane_vals_i,
  output logic [LANES-1:0]    active_mask,
  output logic [LANES-1:0]    pred_mask,
  output logic                br_taken,
  output logic [DW-1:0]       stk_depth,
  output logic                stk_empty,
  output logic                stk_full,
  output logic                ovf_err,
  output logic                udf_err
);
  logic [LANES-1:0] then_m, else_m;
  logic             is_cmp, is_br, is_sw, is_rs, diverge, do_push, do_pop;
  frame_t           top_f, new_f;

  assign is_cmp  = (op_i == OP_CMP);
  assign is_br   = (op_i == OP_BRANCH);
  assign is_sw   = (op_i == OP_SWITCH);
  assign is_rs   = (op_i == OP_RESTORE);
  assign then_m  = active_mask & pred_mask;
  assign else_m  = active_mask & ~pred_mask;
  assign diverge = (then_m != '0) && (else_m != '0);
  assign do_push = is_br && diverge && !stk_full;
  assign do_pop  = is_rs && !stk_empty;
  assign new_f   = '{saved: active_mask, alt: else_m};

  simt_pred_unit #(.LANES(LANES), .VW(VW)) pred_i (
    .clk(clk), .rst_n(rst_n), .load_en(is_cmp),
    .vals(lane_vals_i), .pred(pred_mask)
  );

  simt_frame_stack #(.DEPTH(DEPTH)) stack_i (
    .clk(clk), .rst_n(rst_n), .push(do_push), .pop(do_pop),
    .push_frame(new_f), .top_frame(top_f), .depth(stk_depth),
    .empty(stk_empty), .full(stk_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_mask <= '1;
      br_taken    <= 1'b0;
      ovf_err     <= 1'b0;
      udf_err     <= 1'b0;
    end else begin
      br_taken <= 1'b0;
      ovf_err  <= 1'b0;
      udf_err  <= 1'b0;
      if (is_br) begin
        if (then_m == '0)      br_taken    <= 1'b1;
        else if (do_push)      active_mask <= then_m;
        else if (diverge)      ovf_err     <= 1'b1;
      end else if (is_sw) begin
        if (stk_empty) udf_err     <= 1'b1;
        else           active_mask <= top_f.alt;
      end else if (is_rs) begin
        if (stk_empty) udf_err     <= 1'b1;
        else           active_mask <= top_f.saved;
      end
    end
  end

  // R2
  cmp_keeps_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmp |=> $stable(active_mask));

  // R3
  branch_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_br |=> ((active_mask & ~$past(active_mask)) == '0));

  // R4
  taken_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> $stable(stk_depth));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_rs || is_sw) && stk_empty) |=> (udf_err && $stable(active_mask)));

  // R8
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> ($stable(active_mask) && stk_full));
endmodule

// File: tb/simt_div_ctrl_tb.sv
module simt_div_ctrl_tb_top;
  localparam int DEPTH = 4;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  op_i = 0;
  logic [63:0] lane_vals_i = 0;
  logic [7:0]  active_mask, pred_mask;
  logic        br_taken, stk_empty, stk_full, ovf_err, udf_err;
  logic [2:0]  stk_depth;

  int checks = 0, errs = 0;
  bit done = 0;

  int m_mask, m_pred, m_taken, m_ovf, m_udf;
  int q_saved[$], q_alt[$];

  always #10 clk = ~clk;

  simt_div_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .lane_vals_i(lane_vals_i),
    .active_mask(active_mask), .pred_mask(pred_mask), .br_taken(br_taken),
    .stk_depth(stk_depth), .stk_empty(stk_empty), .stk_full(stk_full),
    .ovf_err(ovf_err), .udf_err(udf_err)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R3/R5/R6/R9 active_mask", active_mask, m_mask);
    chk("R2 pred_mask", pred_mask, m_pred);
    chk("R4 br_taken", br_taken, m_taken);
    chk("R3/R6 stk_depth", stk_depth, q_saved.size());
    chk("R7 stk_empty", stk_empty, q_saved.size() == 0);
    chk("R8 stk_full", stk_full, q_saved.size() == DEPTH);
    chk("R8 ovf_err", ovf_err, m_ovf);
    chk("R7 udf_err", udf_err, m_udf);
  endtask

  function automatic logic [63:0] vals_from(logic [7:0] bits);
    logic [63:0] v = '0;
    for (int i = 0; i < 8; i++)
      v[i*8 +: 8] = bits[i] ? 8'((i * 37 + 1) | 8'h80 >> (i % 8)) : 8'h00;
    return v;
  endfunction

  task automatic step(int op, logic [63:0] vals);
    int th, el;
    op_i = 3'(op);
    lane_vals_i = vals;
    @(posedge clk);
    m_taken = 0; m_ovf = 0; m_udf = 0;
    case (op)
      1: begin
        m_pred = 0;
        for (int i = 0; i < 8; i++) if (vals[i*8 +: 8] != 0) m_pred |= (1 << i);
      end
      2: begin
        th = m_mask & m_pred;
        el = m_mask & ~m_pred & 8'hFF;
        if (th == 0) m_taken = 1;
        else if (el != 0) begin
          if (q_saved.size() == DEPTH) m_ovf = 1;
          else begin
            q_saved.push_back(m_mask);
            q_alt.push_back(el);
            m_mask = th;
          end
        end
      end
      3: if (q_saved.size() == 0) m_udf = 1; else m_mask = q_alt[$];
      4: if (q_saved.size() == 0) m_udf = 1;
         else begin
           m_mask = q_saved.pop_back();
           void'(q_alt.pop_back());
         end
      default: ;
    endcase
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  endtask

  initial begin
    m_mask = 8'hFF; m_pred = 0; m_taken = 0; m_ovf = 0; m_udf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    compare_all();
    chk("R1 reset mask", active_mask, 8'hFF);

    // R2: compare on the sample operands, mask untouched
    step(1, {8'd2, 8'd4, 8'd0, 8'd1, 8'd7, 8'd0, 8'd3, 8'd5});
    chk("R2 pred pattern", pred_mask, 8'hDB);
    // R3: divergent split
    step(2, 0);
    chk("R3 then mask", active_mask, 8'hDB);
    // R5: switch to else lanes
    step(3, 0);
    chk("R5 else mask", active_mask, 8'h24);
    // R6: restore
    step(4, 0);
    chk("R6 restored mask", active_mask, 8'hFF);

    // R4: uniform true and uniform false
    step(1, vals_from(8'hFF));
    step(2, 0);
    chk("R4 uniform true no take", br_taken, 0);
    step(1, 0);
    step(2, 0);
    chk("R4 uniform false taken", br_taken, 1);
    chk("R4 depth kept", stk_depth, 0);

    // R4: inactive lanes ignored
    step(1, vals_from(8'hDB));
    step(2, 0);
    step(1, vals_from(8'h24));
    step(2, 0);
    chk("R4 idle lanes ignored", br_taken, 1);
    step(4, 0);

    // R10: idle and unused codes
    for (int c = 5; c < 8; c++) step(c, vals_from(8'h55));
    step(0, vals_from(8'h55));
    chk("R10 no change", active_mask, 8'hFF);

    // R8/R9: fill the stack then overflow
    step(1, vals_from(8'h7F)); step(2, 0);
    step(1, vals_from(8'h3F)); step(2, 0);
    step(1, vals_from(8'h1F)); step(2, 0);
    step(1, vals_from(8'h0F)); step(2, 0);
    chk("R8 full flag", stk_full, 1);
    step(1, vals_from(8'h07)); step(2, 0);
    chk("R8 overflow pulse", ovf_err, 1);
    chk("R8 mask held", active_mask, 8'h0F);
    step(3, 0);
    chk("R5 nested else", active_mask, 8'h10);
    step(4, 0); chk("R9 level 3", active_mask, 8'h1F);
    step(4, 0); chk("R9 level 2", active_mask, 8'h3F);
    step(4, 0); chk("R9 level 1", active_mask, 8'h7F);
    step(4, 0); chk("R9 level 0", active_mask, 8'hFF);

    // R7: underflow
    step(4, 0);
    chk("R7 restore empty", udf_err, 1);
    step(3, 0);
    chk("R7 switch empty", udf_err, 1);
    step(0, 0);
    chk("R7 pulse clears", udf_err, 0);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule